// File: doc/BRIEF.md
# Multi-Target Serial Register Loader

This block is the serial configuration front end of a sixteen-channel LED sink controller. One serial port, clocked by the serial clock, feeds one of three shift registers: the per-channel grayscale words, the per-channel brightness codes, or the output-voltage-monitor threshold. A two-bit select input picks the target. A separate strobe copies the chosen shift register into its holding latch, and the latches drive the rest of the controller.

The serial output carries the last bit of the selected register. Its launch edge can be the rising or the falling edge of the serial clock. An output-enable line lets several devices share one chain. The brightness and monitor latches each have an enable input. While an enable is low, its latch is held at a default code and strobes to that latch are ignored.

The grayscale register always holds sixteen bits per channel. A width input decides whether the chain uses all of it or only the lower half, which gives eight bits per channel.

Top module: `ledSerialLoader`

## Requirements
- R1: Select code 00 shifts the grayscale register, 01 the brightness register and 10 the monitor register. On each rising serial-clock edge the selected register moves one place toward its MSB and takes `serIn` at bit 0. Registers that are not selected keep their contents.
- R2: Select code 11 shifts no register and drives `serOutEn` low. A strobe applied under code 11 loads no latch.
- R3: With `soEdgeSel` low, `serOut` shows the selected register's tail bit and changes right after the rising edge.
- R4: With `soEdgeSel` high, `serOut` keeps the previous tail bit until the next falling edge and then shows the new one.
- R5: A rising edge with `latchStb` high copies the selected shift register into its latch. The copy is the content from before that same edge's shift.
- R6: Without a strobe, shifting never changes any latch.
- R7: While `brtEn` is low, `brtLatch` is forced to all ones in every 7-bit channel field (100 % current, clock divide 1/1), and brightness strobes are ignored.
- R8: While `monEn` is low, `monLatch` is forced to 2'b00 (the 0.3 V threshold), and monitor strobes are ignored.
- R9: With `wideMode` high, the grayscale tail is bit 255 (16 bits per channel). With it low, the tail is bit 127 (channel i in bits 8i+7..8i).
- R10: After reset, all shift registers and `gsLatch` are zero, `brtLatch` and `monLatch` hold their default codes, and `serOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | serial clock |
| rstN | input | 1 | asynchronous active-low reset |
| serIn | input | 1 | serial data in |
| regSel | input | 2 | target select: 00 grayscale, 01 brightness, 10 monitor, 11 none |
| latchStb | input | 1 | copy selected shift register into its latch |
| wideMode | input | 1 | 1: 16-bit grayscale words, 0: 8-bit |
| soEdgeSel | input | 1 | 0: rising-edge launch, 1: falling-edge launch |
| brtEn | input | 1 | brightness latch write enable; low forces default |
| monEn | input | 1 | monitor latch write enable; low forces default |
| serOut | output | 1 | tail bit of the selected register |
| serOutEn | output | 1 | output enable for the tri-state serial driver |
| gsLatch | output | 256 | latched grayscale data |
| brtLatch | output | 112 | latched brightness codes |
| monLatch | output | 2 | latched monitor threshold |

## Verification
A shift and a latch strobe can land on the same rising edge. In that case the latch must capture the pre-shift image while the register advances. The bench raises `latchStb` on the final shifting edge of a sequence and compares the latch with a model snapshot taken before that edge's shift. A brightness strobe can also coincide with a low enable. The bench drives both together and expects the all-ones default to win.

// File: rtl/ledSerPkg.sv
package ledSerPkg;
  typedef enum logic [1:0] {
    SEL_GS   = 2'b00,
    SEL_BRT  = 2'b01,
    SEL_MON  = 2'b10,
    SEL_NONE = 2'b11
  } selCode_t;

  typedef struct packed {
    logic     shiftGs;
    logic     shiftBrt;
    logic     shiftMon;
    logic     loadGs;
    logic     loadBrt;
    logic     loadMon;
    logic     forceBrt;
    logic     forceMon;
    logic     outEn;
    selCode_t tailSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/ledSerCtrl.sv
module ledSerCtrl
  import ledSerPkg::*;
(
  input  logic [1:0]  regSel,
  input  logic        latchStb,
  input  logic        brtEn,
  input  logic        monEn,
  output ctrlStrobe_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.tailSel  = selCode_t'(regSel);
    strobes.forceBrt = ~brtEn;
    strobes.forceMon = ~monEn;
    unique case (selCode_t'(regSel))
      SEL_GS: begin
        strobes.shiftGs = 1'b1;
        strobes.loadGs  = latchStb;
        strobes.outEn   = 1'b1;
      end
      SEL_BRT: begin
        strobes.shiftBrt = 1'b1;
        strobes.loadBrt  = latchStb & brtEn;
        strobes.outEn    = 1'b1;
      end
      SEL_MON: begin
        strobes.shiftMon = 1'b1;
        strobes.loadMon  = latchStb & monEn;
        strobes.outEn    = 1'b1;
      end
      default: strobes.outEn = 1'b0;
    endcase
  end
endmodule

// File: rtl/ledSerPath.sv
module ledSerPath
  import ledSerPkg::*;
#(
  parameter int CH       = 16,
  parameter int GS_BITS  = 16,
  parameter int BRT_BITS = 7,
  parameter int MON_BITS = 2,
  parameter logic [BRT_BITS-1:0] BRT_DEF = '1,
  parameter logic [MON_BITS-1:0] MON_DEF = '0,
  localparam int GS_W  = CH * GS_BITS,
  localparam int BRT_W = CH * BRT_BITS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              wideMode,
  input  logic              soEdgeSel,
  input  ctrlStrobe_t       strobes,
  output logic              serOut,
  output logic [GS_W-1:0]   gsLatch,
  output logic [BRT_W-1:0]  brtLatch,
  output logic [MON_BITS-1:0] monLatch
);
  localparam int NARROW_TOP = (CH * (GS_BITS / 2)) - 1;

  logic [GS_W-1:0]     gsShift;
  logic [BRT_W-1:0]    brtShift;
  logic [MON_BITS-1:0] monShift;
  logic [BRT_W-1:0]    brtDefAll;
  logic                tailNow;
  logic                tailFall;

  for (genvar c = 0; c < CH; c++) begin : gBrtDef
    assign brtDefAll[c*BRT_BITS +: BRT_BITS] = BRT_DEF;
  end

  // shift registers: serial bit enters at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gsShift  <= '0;
      brtShift <= '0;
      monShift <= '0;
    end else begin
      if (strobes.shiftGs)  gsShift  <= {gsShift[GS_W-2:0], serIn};
      if (strobes.shiftBrt) brtShift <= {brtShift[BRT_W-2:0], serIn};
      if (strobes.shiftMon) monShift <= {monShift[MON_BITS-2:0], serIn};
    end
  end

  // holding latches: copy pre-shift image, enables force defaults
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gsLatch  <= '0;
      brtLatch <= brtDefAll;
      monLatch <= MON_DEF;
    end else begin
      if (strobes.loadGs) gsLatch <= gsShift;
      if (strobes.forceBrt)     brtLatch <= brtDefAll;
      else if (strobes.loadBrt) brtLatch <= brtShift;
      if (strobes.forceMon)     monLatch <= MON_DEF;
      else if (strobes.loadMon) monLatch <= monShift;
    end
  end

  always_comb begin
    unique case (strobes.tailSel)
      SEL_GS:  tailNow = wideMode ? gsShift[GS_W-1] : gsShift[NARROW_TOP];
      SEL_BRT: tailNow = brtShift[BRT_W-1];
      SEL_MON: tailNow = monShift[MON_BITS-1];
      default: tailNow = 1'b0;
    endcase
  end

  // falling-edge launch stage
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) tailFall <= 1'b0;
    else       tailFall <= tailNow;
  end

  assign serOut = soEdgeSel ? tailFall : tailNow;
endmodule

// File: rtl/ledSerialLoader.sv
module ledSerialLoader
  import ledSerPkg::*;
#(
  parameter int CH       = 16,
  parameter int GS_BITS  = 16,
  parameter int BRT_BITS = 7,
  parameter int MON_BITS = 2,
  parameter logic [BRT_BITS-1:0] BRT_DEF = '1,
  parameter logic [MON_BITS-1:0] MON_DEF = '0
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serIn,
  input  logic [1:0]               regSel,
  input  logic                     latchStb,
  input  logic                     wideMode,
  input  logic                     soEdgeSel,
  input  logic                     brtEn,
  input  logic                     monEn,
  output logic                     serOut,
  output logic                     serOutEn,
  output logic [CH*GS_BITS-1:0]    gsLatch,
  output logic [CH*BRT_BITS-1:0]   brtLatch,
  output logic [MON_BITS-1:0]      monLatch
);
  ctrlStrobe_t strobes;

  ledSerCtrl u_ctrl (
    .regSel   (regSel),
    .latchStb (latchStb),
    .brtEn    (brtEn),
    .monEn    (monEn),
    .strobes  (strobes)
  );

  ledSerPath #(
    .CH(CH), .GS_BITS(GS_BITS), .BRT_BITS(BRT_BITS), .MON_BITS(MON_BITS),
    .BRT_DEF(BRT_DEF), .MON_DEF(MON_DEF)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .serIn     (serIn),
    .wideMode  (wideMode),
    .soEdgeSel (soEdgeSel),
    .strobes   (strobes),
    .serOut    (serOut),
    .gsLatch   (gsLatch),
    .brtLatch  (brtLatch),
    .monLatch  (monLatch)
  );

  assign serOutEn = strobes.outEn;
endmodule

// File: rtl/ledSerLoaderChk.sv
module ledSerLoaderChk #(
  parameter int CH       = 16,
  parameter int GS_BITS  = 16,
  parameter int BRT_BITS = 7,
  parameter int MON_BITS = 2,
  parameter logic [BRT_BITS-1:0] BRT_DEF = '1,
  parameter logic [MON_BITS-1:0] MON_DEF = '0
)(
  input logic                   clk,
  input logic                   rstN,
  input logic                   serIn,
  input logic [1:0]             regSel,
  input logic                   latchStb,
  input logic                   wideMode,
  input logic                   soEdgeSel,
  input logic                   brtEn,
  input logic                   monEn,
  input logic                   serOut,
  input logic                   serOutEn,
  input logic [CH*GS_BITS-1:0]  gsLatch,
  input logic [CH*BRT_BITS-1:0] brtLatch,
  input logic [MON_BITS-1:0]    monLatch
);
  assert_none_tristate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'b11) |-> !serOutEn);

  assert_gs_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !latchStb |=> $stable(gsLatch));

  assert_brt_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!latchStb && brtEn) |=> $stable(brtLatch));

  assert_mon_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!latchStb && monEn) |=> $stable(monLatch));

  assert_brt_default_R7: assert property (@(posedge clk) disable iff (!rstN)
    !brtEn |=> (brtLatch == {CH{BRT_DEF}}));

  assert_mon_default_R8: assert property (@(posedge clk) disable iff (!rstN)
    !monEn |=> (monLatch == MON_DEF));

  assert_gs_untouched_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'b11) |=> $stable(gsLatch));
endmodule

bind ledSerialLoader ledSerLoaderChk #(
  .CH(CH), .GS_BITS(GS_BITS), .BRT_BITS(BRT_BITS), .MON_BITS(MON_BITS),
  .BRT_DEF(BRT_DEF), .MON_DEF(MON_DEF)
) u_chk (.*);

// File: tb/ledSerialLoader_bench.sv
module ledSerialLoader_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic [1:0] regSel = 2'b00;
  logic latchStb = 1'b0;
  logic wideMode = 1'b1;
  logic soEdgeSel = 1'b0;
  logic brtEn = 1'b1;
  logic monEn = 1'b1;
  logic serOut, serOutEn;
  logic [255:0] gsLatch;
  logic [111:0] brtLatch;
  logic [1:0]   monLatch;

  int checks = 0;
  int errors = 0;

  localparam logic [111:0] BRT_DEF_ALL = {16{7'h7F}};

  // vector: {sel[1:0], wide, count[8:0], seed[7:0]}
  localparam logic [19:0] VEC [6] = '{
    {2'd0, 1'b1, 9'd256, 8'hA5},
    {2'd0, 1'b0, 9'd128, 8'h3C},
    {2'd1, 1'b1, 9'd112, 8'h96},
    {2'd2, 1'b1, 9'd2,   8'h02},
    {2'd1, 1'b1, 9'd40,  8'h5F},
    {2'd0, 1'b1, 9'd20,  8'hC3}
  };

  logic [255:0] mGs = '0, mLGs = '0;
  logic [111:0] mBrt = '0, mLBrt = BRT_DEF_ALL;
  logic [1:0]   mMon = '0, mLMon = '0;

  ledSerialLoader u_ledSerialLoader (
    .clk(clk), .rstN(rstN), .serIn(serIn), .regSel(regSel),
    .latchStb(latchStb), .wideMode(wideMode), .soEdgeSel(soEdgeSel),
    .brtEn(brtEn), .monEn(monEn), .serOut(serOut), .serOutEn(serOutEn),
    .gsLatch(gsLatch), .brtLatch(brtLatch), .monLatch(monLatch)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic expTail();
    case (regSel)
      2'd0:    return wideMode ? mGs[255] : mGs[127];
      2'd1:    return mBrt[111];
      2'd2:    return mMon[1];
      default: return 1'b0;
    endcase
  endfunction

  // one rising edge; model updated from inputs in effect at that edge
  task automatic tick();
    @(posedge clk);
    if (latchStb) begin
      case (regSel)
        2'd0: mLGs = mGs;
        2'd1: if (brtEn) mLBrt = mBrt;
        2'd2: if (monEn) mLMon = mMon;
        default: ;
      endcase
    end
    if (!brtEn) mLBrt = BRT_DEF_ALL;
    if (!monEn) mLMon = 2'b00;
    case (regSel)
      2'd0: mGs  = {mGs[254:0], serIn};
      2'd1: mBrt = {mBrt[110:0], serIn};
      2'd2: mMon = {mMon[0], serIn};
      default: ;
    endcase
    #1;
  endtask

  task automatic checkLatches(input string tag);
    chk(gsLatch == mLGs, tag, gsLatch, mLGs);
    chk(brtLatch == mLBrt, tag, {144'd0, brtLatch}, {144'd0, mLBrt});
    chk(monLatch == mLMon, tag, {254'd0, monLatch}, {254'd0, mLMon});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10 reset state
    checkLatches("R10 reset latches");
    chk(serOut == 1'b0, "R10 reset serOut", {255'd0, serOut}, 256'd0);
    chk(serOutEn == 1'b1, "R10 reset serOutEn", {255'd0, serOutEn}, 256'd1);

    // table walk: R1 shifting, R9 width, R5 strobe on last shifting edge
    for (int v = 0; v < 6; v++) begin
      logic [1:0] vs;
      logic       vw;
      logic [8:0] vc;
      logic [7:0] vd;
      {vs, vw, vc, vd} = VEC[v];
      regSel = vs; wideMode = vw; soEdgeSel = 1'b0;
      for (int k = 0; k < vc; k++) begin
        serIn = vd[k % 8] ^ k[4];
        latchStb = (k == vc - 1);
        tick();
        chk(serOut == expTail(), "R1 R9 tail bit", {255'd0, serOut}, {255'd0, expTail()});
      end
      latchStb = 1'b0;
      checkLatches("R5 strobe with shift");
      tick();
      checkLatches("R6 no strobe hold");
    end

    // R2: select 11 shifts nothing, loads nothing, tri-states output
    regSel = 2'b11; serIn = 1'b1; latchStb = 1'b1;
    repeat (3) tick();
    chk(serOutEn == 1'b0, "R2 serOutEn low", {255'd0, serOutEn}, 256'd0);
    checkLatches("R2 no load");
    latchStb = 1'b0; regSel = 2'b01;
    #1;
    chk(serOut == mBrt[111], "R2 brt untouched", {255'd0, serOut}, {255'd0, mBrt[111]});
    regSel = 2'b00; latchStb = 1'b1;
    tick();
    latchStb = 1'b0;
    checkLatches("R2 gs untouched");

    // R3 rising-edge launch
    regSel = 2'b00; wideMode = 1'b1; soEdgeSel = 1'b0;
    for (int k = 0; k < 6; k++) begin
      serIn = k[0];
      tick();
      chk(serOut == expTail(), "R3 rising launch", {255'd0, serOut}, {255'd0, expTail()});
    end
    // R4 falling-edge launch
    soEdgeSel = 1'b1;
    tick();
    #5;
    for (int k = 0; k < 8; k++) begin
      logic prevTail;
      prevTail = expTail();
      serIn = ~k[1];
      tick();
      chk(serOut == prevTail, "R4 holds until fall", {255'd0, serOut}, {255'd0, prevTail});
      #5;
      chk(serOut == expTail(), "R4 new after fall", {255'd0, serOut}, {255'd0, expTail()});
    end
    soEdgeSel = 1'b0;

    // R7: brightness enable low forces default, strobe ignored
    regSel = 2'b01;
    for (int k = 0; k < 10; k++) begin serIn = 1'b0; tick(); end
    latchStb = 1'b1; tick(); latchStb = 1'b0;
    checkLatches("R5 brt load zeros");
    brtEn = 1'b0; latchStb = 1'b1;
    tick();
    checkLatches("R7 forced with strobe");
    chk(brtLatch == BRT_DEF_ALL, "R7 default code", {144'd0, brtLatch}, {144'd0, BRT_DEF_ALL});
    latchStb = 1'b0; brtEn = 1'b1;
    tick();
    checkLatches("R7 default kept after enable");

    // R8: monitor enable low forces default
    regSel = 2'b10; serIn = 1'b1;
    tick(); tick();
    latchStb = 1'b1; tick(); latchStb = 1'b0;
    chk(monLatch == 2'b11, "R8 pre-load", {254'd0, monLatch}, {254'd0, 2'b11});
    monEn = 1'b0; latchStb = 1'b1;
    tick();
    chk(monLatch == 2'b00, "R8 forced default", {254'd0, monLatch}, 256'd0);
    latchStb = 1'b0; monEn = 1'b1;
    tick();
    checkLatches("R8 after enable");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule